// File: doc/BRIEF.md
# Power-up reset timeout sequencer

This block decides when the internal chip reset may be let go after power is applied, after the supply sags, or while an external reset pin is held low. It chains up to three waits. The first is a power-up delay counted on strobes from a slow on-chip RC oscillator. The second is an oscillator settling delay counted on strobes from the main oscillator. The third is a PLL lock wait, counted again on the slow RC strobes. Which waits run depends on the oscillator mode code and on a configuration bit that turns the power-up delay off.

The whole block runs on one clock. The power-on pulse doubles as its synchronous, active-high reset. The slow RC tick and the main oscillator tick arrive as one-cycle enable strobes. A filtered low-supply flag from an analog comparator triggers a brown-out hold when brown-out detection is enabled. Three sticky flags tell software which reset sources have fired since the last power-on.

Top module: `rst_timeout_seq`

## Requirements
- R1: While `por_i` is high, `rst_hold_o` is high. On the first clock after `por_i` has been sampled high, the flags read power-on = 1, brown-out = 0, external = 0.
- R2: When `pwrt_off_i` = 0, a power-on or a brown-out recovery starts a power-up delay. The delay ends on the clock edge that samples the 2**PWRT_W-th `rc_tick_i` strobe, and reset is held until then.
- R3: When `pwrt_off_i` = 1, the power-up delay stage is skipped.
- R4: After a power-on, mode codes 0 to 3 (low-power crystal, crystal, high-speed, high-speed with PLL) add an oscillator settling stage of OST_CYCLES `osc_tick_i` strobes. Codes 4 to 7 (RC and external-clock modes) skip it.
- R5: Mode code 3 adds a PLL lock stage of PLL_TICKS `rc_tick_i` strobes after the oscillator settling stage.
- R6: With `bor_en_i` = 1 and `low_supply_i` = 1, reset is held at once and stays held while the flag stays high. With `bor_en_i` = 0, `low_supply_i` has no effect.
- R7: After brown-out recovery, only the power-up delay runs, if it is enabled. The oscillator and PLL stages never run. With the delay disabled, reset is released on the first clock after the flag clears.
- R8: If the brown-out condition is present during any wait, the block returns to the brown-out state and the count restarts from zero. This holds even when the brown-out coincides with the strobe that would end the count.
- R9: The external pin `ext_rst_n_i` low holds reset but neither starts nor restarts any wait. If the pin stays low until all waits have expired, reset drops in the same cycle the pin goes high.
- R10: In an RC mode (code 4 to 7) with `pwrt_off_i` = 1, `rst_hold_o` equals `por_i` OR NOT `ext_rst_n_i`, with no added delay.
- R11: The brown-out flag sets on entry into brown-out and the external flag sets on any clock with the pin low. Both stay set until the next power-on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| por_i | input | 1 | Power-on pulse, synchronous active-high reset of the block |
| ext_rst_n_i | input | 1 | External reset pin, active low |
| bor_en_i | input | 1 | Brown-out detection enable |
| low_supply_i | input | 1 | Filtered low-supply comparator flag |
| pwrt_off_i | input | 1 | 1 disables the power-up delay stage |
| osc_mode_i | input | 3 | Oscillator mode code |
| rc_tick_i | input | 1 | One-cycle strobe from the slow RC oscillator |
| osc_tick_i | input | 1 | One-cycle strobe per main oscillator cycle |
| rst_hold_o | output | 1 | Internal reset held while high |
| flag_por_o | output | 1 | Sticky: power-on reset occurred |
| flag_bor_o | output | 1 | Sticky: brown-out reset occurred |
| flag_ext_o | output | 1 | Sticky: external pin reset occurred |

## Verification
The delicate overlap is a brown-out arriving on the same clock as the RC strobe that would end the power-up count. In that cycle the stage would advance and the low-supply flag would force a return to brown-out. The bench arms a trigger that raises the low-supply flag exactly when the slow strobe carrying the last count is driven. A behavioural model, compared on every clock, then expects the brown-out to win: reset stays held and the full delay runs again from zero after recovery. The same per-cycle comparison covers a brown-out in the middle of the count, external-pin pulses during the waits, and the pin held low past every expiry.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

    typedef enum logic [2:0] {
        ST_DONE  = 3'd0,
        ST_PWRT  = 3'd1,
        ST_OST   = 3'd2,
        ST_PLL   = 3'd3,
        ST_BROWN = 3'd4
    } seq_stage_e;

    typedef logic [2:0] osc_mode_t;

    localparam osc_mode_t MODE_HS_PLL = 3'd3;

    typedef struct packed {
        logic por;
        logic brown;
        logic ext;
    } src_flags_t;

    // Codes 0..3 drive a crystal or resonator and need settling time
    function automatic logic is_crystal(osc_mode_t mode);
        return (mode[2] == 1'b0);
    endfunction

    function automatic logic has_pll(osc_mode_t mode);
        return (mode == MODE_HS_PLL);
    endfunction

    // First stage entered after a power-on pulse
    function automatic seq_stage_e cold_entry(logic pwrt_on, osc_mode_t mode);
        if (pwrt_on)
            return ST_PWRT;
        else if (is_crystal(mode))
            return ST_OST;
        else
            return ST_DONE;
    endfunction

    function automatic int max3(int a, int b, int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/rst_seq_timer.sv
module rst_seq_timer #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             clear_i,
    input  logic             step_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             expire_o
);

    logic [CNT_W-1:0] cnt_q;

    // limit_i holds the terminal value (event count minus one)
    assign expire_o = step_i && (cnt_q == limit_i);
    assign cnt_o    = cnt_q;

    always_ff @(posedge clk) begin
        if (clear_i)
            cnt_q <= '0;
        else if (step_i) begin
            if (cnt_q == limit_i)
                cnt_q <= '0;
            else
                cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
    import rst_seq_pkg::*;
#(
    parameter int               CNT_W     = 11,
    parameter logic [CNT_W-1:0] PWRT_LAST = '1,
    parameter logic [CNT_W-1:0] OST_LAST  = '1,
    parameter logic [CNT_W-1:0] PLL_LAST  = '1
) (
    input  logic             clk,
    input  logic             por_i,
    input  logic             pwrt_on_i,
    input  logic             brown_i,
    input  osc_mode_t        mode_i,
    input  logic             rc_tick_i,
    input  logic             osc_tick_i,
    input  logic             expire_i,
    output seq_stage_e       stage_o,
    output logic             clear_o,
    output logic             step_o,
    output logic [CNT_W-1:0] limit_o,
    output logic             brown_entry_o
);

    seq_stage_e stg_q, stg_d;
    logic       cold_q, cold_d;

    always_comb begin
        stg_d   = stg_q;
        cold_d  = cold_q;
        step_o  = 1'b0;
        limit_o = PWRT_LAST;
        unique case (stg_q)
            ST_PWRT: begin
                step_o  = rc_tick_i;
                limit_o = PWRT_LAST;
                if (expire_i)
                    stg_d = (cold_q && is_crystal(mode_i)) ? ST_OST : ST_DONE;
            end
            ST_OST: begin
                step_o  = osc_tick_i;
                limit_o = OST_LAST;
                if (expire_i)
                    stg_d = has_pll(mode_i) ? ST_PLL : ST_DONE;
            end
            ST_PLL: begin
                step_o  = rc_tick_i;
                limit_o = PLL_LAST;
                if (expire_i)
                    stg_d = ST_DONE;
            end
            ST_BROWN: begin
                stg_d = pwrt_on_i ? ST_PWRT : ST_DONE;
            end
            default: begin
                stg_d = stg_q;
            end
        endcase
        // Brown-out overrides any advance in the same cycle
        if (brown_i) begin
            stg_d  = ST_BROWN;
            cold_d = 1'b0;
        end
    end

    assign clear_o       = (stg_d != stg_q);
    assign brown_entry_o = brown_i && (stg_q != ST_BROWN);
    assign stage_o       = stg_q;

    always_ff @(posedge clk) begin
        if (por_i) begin
            stg_q  <= cold_entry(pwrt_on_i, mode_i);
            cold_q <= 1'b1;
        end else begin
            stg_q  <= stg_d;
            cold_q <= cold_d;
        end
    end

endmodule

// File: rtl/rst_seq_flags.sv
module rst_seq_flags
    import rst_seq_pkg::*;
(
    input  logic       clk,
    input  logic       por_i,
    input  logic       brown_entry_i,
    input  logic       ext_low_i,
    output src_flags_t flags_o
);

    src_flags_t flags_q;

    always_ff @(posedge clk) begin
        if (por_i) begin
            flags_q.por   <= 1'b1;
            flags_q.brown <= 1'b0;
            flags_q.ext   <= 1'b0;
        end else begin
            flags_q.por   <= flags_q.por;
            flags_q.brown <= flags_q.brown | brown_entry_i;
            flags_q.ext   <= flags_q.ext | ext_low_i;
        end
    end

    assign flags_o = flags_q;

endmodule

// File: rtl/rst_timeout_seq.sv
module rst_timeout_seq
    import rst_seq_pkg::*;
#(
    parameter int PWRT_W     = 11,
    parameter int OST_CYCLES = 1024,
    parameter int PLL_TICKS  = 64
) (
    input  logic       clk,
    input  logic       por_i,
    input  logic       ext_rst_n_i,
    input  logic       bor_en_i,
    input  logic       low_supply_i,
    input  logic       pwrt_off_i,
    input  logic [2:0] osc_mode_i,
    input  logic       rc_tick_i,
    input  logic       osc_tick_i,
    output logic       rst_hold_o,
    output logic       flag_por_o,
    output logic       flag_bor_o,
    output logic       flag_ext_o
);

    localparam int PWRT_COUNT = 1 << PWRT_W;
    localparam int CNT_W = max3(PWRT_W, $clog2(OST_CYCLES), $clog2(PLL_TICKS));
    localparam logic [CNT_W-1:0] PWRT_LAST = CNT_W'(PWRT_COUNT - 1);
    localparam logic [CNT_W-1:0] OST_LAST  = CNT_W'(OST_CYCLES - 1);
    localparam logic [CNT_W-1:0] PLL_LAST  = CNT_W'(PLL_TICKS - 1);

    seq_stage_e       stage;
    logic             brown_act;
    logic             ctrl_clear;
    logic             tmr_clear;
    logic             tmr_step;
    logic             tmr_expire;
    logic [CNT_W-1:0] tmr_limit;
    logic [CNT_W-1:0] tmr_cnt;
    logic             brown_entry;
    src_flags_t       flags;

    assign brown_act = bor_en_i & low_supply_i;
    assign tmr_clear = por_i | ctrl_clear;

    rst_seq_ctrl #(
        .CNT_W     (CNT_W),
        .PWRT_LAST (PWRT_LAST),
        .OST_LAST  (OST_LAST),
        .PLL_LAST  (PLL_LAST)
    ) ctrl_i (
        .clk           (clk),
        .por_i         (por_i),
        .pwrt_on_i     (~pwrt_off_i),
        .brown_i       (brown_act),
        .mode_i        (osc_mode_i),
        .rc_tick_i     (rc_tick_i),
        .osc_tick_i    (osc_tick_i),
        .expire_i      (tmr_expire),
        .stage_o       (stage),
        .clear_o       (ctrl_clear),
        .step_o        (tmr_step),
        .limit_o       (tmr_limit),
        .brown_entry_o (brown_entry)
    );

    rst_seq_timer #(
        .CNT_W (CNT_W)
    ) timer_i (
        .clk      (clk),
        .clear_i  (tmr_clear),
        .step_i   (tmr_step),
        .limit_i  (tmr_limit),
        .cnt_o    (tmr_cnt),
        .expire_o (tmr_expire)
    );

    rst_seq_flags flags_i (
        .clk           (clk),
        .por_i         (por_i),
        .brown_entry_i (brown_entry),
        .ext_low_i     (~ext_rst_n_i),
        .flags_o       (flags)
    );

    assign rst_hold_o = por_i | ~ext_rst_n_i | brown_act | (stage != ST_DONE);
    assign flag_por_o = flags.por;
    assign flag_bor_o = flags.brown;
    assign flag_ext_o = flags.ext;

endmodule

// File: rtl/rst_timeout_chk.sv
module rst_timeout_chk
    import rst_seq_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input logic             clk,
    input logic             por_i,
    input logic             ext_rst_n_i,
    input logic             bor_en_i,
    input logic             low_supply_i,
    input logic             rst_hold_o,
    input logic             flag_por_o,
    input logic             flag_bor_o,
    input logic             flag_ext_o,
    input logic [CNT_W-1:0] tmr_cnt,
    input seq_stage_e       stage
);

    a_r1_por_flags: assert property (@(posedge clk)
        por_i |=> (flag_por_o && !flag_bor_o && !flag_ext_o));

    a_r6_brown_enters: assert property (@(posedge clk) disable iff (por_i)
        (bor_en_i && low_supply_i) |=> (stage == ST_BROWN));

    a_r6_brown_holds: assert property (@(posedge clk) disable iff (por_i)
        (stage == ST_BROWN) |-> rst_hold_o);

    a_r8_count_reload: assert property (@(posedge clk) disable iff (por_i)
        (bor_en_i && low_supply_i) |=> (tmr_cnt == '0));

    a_r9_done_kept: assert property (@(posedge clk) disable iff (por_i)
        (stage == ST_DONE && !(bor_en_i && low_supply_i)) |=> (stage == ST_DONE));

    a_r11_ext_flag: assert property (@(posedge clk) disable iff (por_i)
        !ext_rst_n_i |=> flag_ext_o);

    a_r11_brown_sticky: assert property (@(posedge clk) disable iff (por_i)
        flag_bor_o |=> flag_bor_o);

endmodule

bind rst_timeout_seq rst_timeout_chk #(.CNT_W(CNT_W)) chk_i (
    .clk          (clk),
    .por_i        (por_i),
    .ext_rst_n_i  (ext_rst_n_i),
    .bor_en_i     (bor_en_i),
    .low_supply_i (low_supply_i),
    .rst_hold_o   (rst_hold_o),
    .flag_por_o   (flag_por_o),
    .flag_bor_o   (flag_bor_o),
    .flag_ext_o   (flag_ext_o),
    .tmr_cnt      (tmr_cnt),
    .stage        (stage)
);

// File: tb/rst_timeout_seq_tb_top.sv
module rst_timeout_seq_tb_top;

    localparam int PW_W  = 4;
    localparam int PW_N  = 16;
    localparam int OST_N = 12;
    localparam int PLL_N = 6;

    logic       clk = 1'b0;
    logic       por = 1'b1;
    logic       ext_n = 1'b1;
    logic       bor_en = 1'b1;
    logic       low = 1'b0;
    logic       pwrt_off = 1'b0;
    logic [2:0] mode = 3'd1;
    logic       rc_tick = 1'b0;
    logic       osc_tick = 1'b0;
    logic       hold, f_por, f_bor, f_ext;

    always #4 clk = ~clk;

    rst_timeout_seq #(
        .PWRT_W     (PW_W),
        .OST_CYCLES (OST_N),
        .PLL_TICKS  (PLL_N)
    ) dut_i (
        .clk          (clk),
        .por_i        (por),
        .ext_rst_n_i  (ext_n),
        .bor_en_i     (bor_en),
        .low_supply_i (low),
        .pwrt_off_i   (pwrt_off),
        .osc_mode_i   (mode),
        .rc_tick_i    (rc_tick),
        .osc_tick_i   (osc_tick),
        .rst_hold_o   (hold),
        .flag_por_o   (f_por),
        .flag_bor_o   (f_bor),
        .flag_ext_o   (f_ext)
    );

    int    checks = 0;
    int    fails = 0;
    string cur_req = "R1";
    int    tick_div = 0;
    bit    arm_bor = 1'b0;
    bit    finished = 1'b0;

    // Behavioural model: 0 released, 1 power-up wait, 2 oscillator wait,
    // 3 PLL wait, 4 brown-out
    int m_stage = 0;
    int m_cnt = 0;
    bit m_cold = 1'b1;
    bit m_fpor = 1'b0, m_fbor = 1'b0, m_fext = 1'b0;

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        if (por) begin
            m_fpor = 1'b1; m_fbor = 1'b0; m_fext = 1'b0;
            m_cold = 1'b1; m_cnt = 0;
            m_stage = !pwrt_off ? 1 : ((mode < 3'd4) ? 2 : 0);
        end else begin
            if (bor_en && low) begin
                if (m_stage != 4) m_fbor = 1'b1;
                m_stage = 4; m_cnt = 0; m_cold = 1'b0;
            end else begin
                case (m_stage)
                    4: begin m_stage = pwrt_off ? 0 : 1; m_cnt = 0; end
                    1: if (rc_tick) begin
                        m_cnt++;
                        if (m_cnt == PW_N) begin
                            m_cnt = 0;
                            m_stage = (m_cold && mode < 3'd4) ? 2 : 0;
                        end
                    end
                    2: if (osc_tick) begin
                        m_cnt++;
                        if (m_cnt == OST_N) begin
                            m_cnt = 0;
                            m_stage = (mode == 3'd3) ? 3 : 0;
                        end
                    end
                    3: if (rc_tick) begin
                        m_cnt++;
                        if (m_cnt == PLL_N) begin m_cnt = 0; m_stage = 0; end
                    end
                    default: ;
                endcase
            end
            if (!ext_n) m_fext = 1'b1;
        end
    end

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!finished) begin
            bit exp_hold;
            exp_hold = por || !ext_n || (bor_en && low) || (m_stage != 0);
            check(hold === exp_hold, cur_req, "rst_hold_o", int'(hold), int'(exp_hold));
            check({f_por, f_bor, f_ext} === {m_fpor, m_fbor, m_fext}, cur_req,
                  "flags por/bor/ext", int'({f_por, f_bor, f_ext}),
                  int'({m_fpor, m_fbor, m_fext}));
        end
    end

    task automatic cyc();
        @(negedge clk);
        #1;
        tick_div++;
        rc_tick  = (tick_div % 3 == 0);
        osc_tick = (tick_div % 2 == 0);
        if (arm_bor && rc_tick && m_stage == 1 && m_cnt == PW_N - 1) begin
            low = 1'b1;
            arm_bor = 1'b0;
        end
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic settle();
        for (int k = 0; k < 2000 && m_stage != 0; k++) cyc();
        run(3);
    endtask

    task automatic do_por();
        por = 1'b1;
        run(3);
        por = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        report();
    end

    initial begin
        // R1: power-on state and flags
        cur_req = "R1";
        run(4);
        por = 1'b0;
        // R2 and R4: crystal mode, power-up then oscillator waits
        cur_req = "R2";
        settle();
        check(hold == 1'b0, "R2", "released after waits", int'(hold), 0);
        // R5: PLL mode adds lock wait
        mode = 3'd3; cur_req = "R5";
        do_por(); settle();
        // R4: RC mode skips oscillator wait
        mode = 3'd5; cur_req = "R4";
        do_por(); settle();
        // R3: power-up wait disabled, high-speed crystal
        mode = 3'd2; pwrt_off = 1'b1; cur_req = "R3";
        do_por(); settle();
        // R10: RC mode with no delay, reset follows pins
        mode = 3'd5; cur_req = "R10";
        do_por(); run(1);
        ext_n = 1'b0; #1;
        check(hold == 1'b1, "R10", "hold follows pin low", int'(hold), 1);
        run(3); ext_n = 1'b1; #1;
        check(hold == 1'b0, "R10", "hold follows pin high", int'(hold), 0);
        run(2);
        // R6 then R7: brown-out and recovery with power-up wait only
        mode = 3'd1; pwrt_off = 1'b0; cur_req = "R6";
        low = 1'b1; run(5);
        low = 1'b0; cur_req = "R7";
        settle();
        check(f_bor == 1'b1, "R11", "brown-out flag sticky", int'(f_bor), 1);
        check(f_ext == 1'b1, "R11", "external flag sticky", int'(f_ext), 1);
        // R6: detection disabled ignores flag
        bor_en = 1'b0; low = 1'b1; cur_req = "R6";
        run(5);
        check(hold == 1'b0, "R6", "disabled brown-out ignored", int'(hold), 0);
        low = 1'b0; bor_en = 1'b1; run(2);
        // R8: brown-out mid count restarts it
        cur_req = "R8";
        low = 1'b1; cyc(); low = 1'b0;
        for (int k = 0; k < 500 && !(m_stage == 1 && m_cnt == 5); k++) cyc();
        low = 1'b1; run(2); low = 1'b0;
        settle();
        // R8: brown-out coincident with final tick
        low = 1'b1; cyc(); low = 1'b0;
        arm_bor = 1'b1;
        for (int k = 0; k < 500 && arm_bor; k++) cyc();
        cyc(); low = 1'b0;
        check(hold == 1'b1, "R8", "coincident brown-out wins", int'(hold), 1);
        settle();
        // R7: recovery with power-up wait disabled
        pwrt_off = 1'b1; cur_req = "R7";
        low = 1'b1; run(3); low = 1'b0; run(3);
        // R9: pin low through every wait, then release at once
        pwrt_off = 1'b0; mode = 3'd1; cur_req = "R9";
        ext_n = 1'b0;
        do_por(); settle();
        check(hold == 1'b1, "R9", "pin still holds", int'(hold), 1);
        ext_n = 1'b1; #1;
        check(hold == 1'b0, "R9", "release on pin high", int'(hold), 0);
        run(2);
        // R9: pin pulse during a wait does not restart it
        do_por(); run(10);
        ext_n = 1'b0; run(3); ext_n = 1'b1;
        settle();
        report();
    end

endmodule